// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router with Acknowledge

This block gathers level-sensitive interrupt lines from the rest of the chip and routes each line to one or more of several CPUs. Software reaches it through two register regions on a simple read/write strobe bus. The shared region holds a control word, the global enable controls and one routing word per source. The per-CPU region holds the acknowledge word and that CPU's own masking controls. A CPU-ID input on each access picks which CPU's bank a per-CPU access reaches.

Global enables and per-CPU masks are never written as bitmaps. Software writes the number of one source to a dedicated "set" or "clear" register, so two agents can change different sources without a read-modify-write race. Each CPU has a level interrupt output. When it reads its acknowledge word, it gets the lowest-numbered source that is deliverable to it. Number 0 is reserved for a pending doorbell (inter-processor) interrupt, and 1023 means nothing is pending.

External sources are numbered 1 to NUM_SRC-1. Number 0 belongs to the per-CPU doorbell input.

Top module: `mcpu_irq_ctrl`

## Requirements
- R1: After reset every source is globally disabled, every number (0 included) is masked for every CPU, every routing word is zero, all irq_out bits are low and every acknowledge read returns 1023.
- R2: A read of the shared control word (bus_bank=0, offset 0x00) returns NUM_SRC in bits [11:2], with all other bits zero.
- R3: Writing n to shared offset 0x30 enables source n, and writing n to shared offset 0x34 disables it. Only when 1 <= n < NUM_SRC does the write change anything, and it leaves every other source untouched; a value of NUM_SRC or more (for example 37) changes nothing.
- R4: Writing n to per-CPU offset 0x48 (bus_bank=1) masks number n for the CPU named by bus_cpu, and writing n to offset 0x4C unmasks it. The masks of the other CPUs stay unchanged, and values of NUM_SRC or more are ignored.
- R5: The routing word of source n sits at shared offset 0x100+4n. Bit c of the word (for c below NUM_CPUS) routes the source to CPU c. The word reads back with all higher bits zero.
- R6: External source n is deliverable to CPU c only when its line is high, it is enabled, it is unmasked for c and routing bit c is set.
- R7: A read of per-CPU offset 0x44 returns, in bits [9:0], the lowest-numbered source deliverable to the addressed CPU. It returns 1023 when no source is deliverable, and the upper bits are zero.
- R8: When db_pend[c] is high and number 0 is unmasked for CPU c, the acknowledge value of CPU c is 0, ahead of any external source. The doorbell needs no enable and no routing.
- R9: irq_out[c] is high exactly when the acknowledge value of CPU c differs from 1023, and it follows input and state changes without any extra register stage.
- R10: Sources are level-sensitive. When a line drops, the source stops being reported, and an acknowledge read changes no state, so repeated reads return the same value.
- R11: Read data appears on bus_rdata from the rising edge that samples bus_rd and holds until the next read. The set/clear registers and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_bank | input | 1 | Region select: 0 shared, 1 per-CPU |
| bus_addr | input | ADDR_W | Byte offset inside the selected region |
| bus_wdata | input | DATA_W | Write data |
| bus_cpu | input | CPU_W | CPU issuing the access, selects the per-CPU bank |
| bus_rdata | output | DATA_W | Registered read data |
| src_level | input | NUM_SRC-1 | Level interrupt lines, bit n is source n (1..NUM_SRC-1) |
| db_pend | input | NUM_CPUS | Doorbell pending, one bit per CPU |
| irq_out | output | NUM_CPUS | Level interrupt to each CPU |

## Verification
The bench writes out-of-range numbers such as 37 to the enable and mask registers. A design that truncates the written value to the index width would then change source 5, and the acknowledge values would expose it. It masks and unmasks on one CPU while watching the others, which catches a mask bank that ignores bus_cpu, and it writes routing words with all upper bits set to show that stray bits neither route nor read back. It also gives a doorbell and a lower external source together, drops lines while they are the winners, and re-reads the acknowledge word. A design with the wrong precedence, a latched level or a side-effecting acknowledge would return the wrong number there.

// File: rtl/mcpu_irq_pkg.sv
package mcpu_irq_pkg;

  localparam int ACK_W = 10;
  localparam logic [ACK_W-1:0] ACK_NONE = 10'd1023;
  localparam logic [ACK_W-1:0] ACK_DBELL = 10'd0;

  // shared region offsets
  localparam int OFS_CTRL     = 'h000;
  localparam int OFS_SET_EN   = 'h030;
  localparam int OFS_CLR_EN   = 'h034;
  localparam int OFS_SRC_BASE = 'h100;

  // per-CPU region offsets
  localparam int OFS_ACK      = 'h044;
  localparam int OFS_SET_MSK  = 'h048;
  localparam int OFS_CLR_MSK  = 'h04C;

  typedef enum logic {
    BANK_SHARED = 1'b0,
    BANK_CPU    = 1'b1
  } bank_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CPU_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr,
  input  logic                               bank,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [CPU_W-1:0]                   cpu,
  output logic [NUM_SRC-1:1]                 en_o,
  output logic [NUM_CPUS-1:0][NUM_SRC-1:0]   mask_o,
  output logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_o
);

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] A_SET_EN  = ADDR_W'(OFS_SET_EN);
  localparam logic [ADDR_W-1:0] A_CLR_EN  = ADDR_W'(OFS_CLR_EN);
  localparam logic [ADDR_W-1:0] A_SET_MSK = ADDR_W'(OFS_SET_MSK);
  localparam logic [ADDR_W-1:0] A_CLR_MSK = ADDR_W'(OFS_CLR_MSK);
  localparam logic [ADDR_W-1:0] A_BASE    = ADDR_W'(OFS_SRC_BASE);
  localparam logic [ADDR_W-1:0] A_SPAN    = ADDR_W'(4 * NUM_SRC);

  logic [NUM_SRC-1:1]               en_q, en_d;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_q, route_d;

  logic [IDX_W-1:0]  idx;
  logic              idx_ok;
  logic              cpu_ok;
  logic [ADDR_W-1:0] rel;
  logic              src_hit;
  logic [IDX_W-1:0]  sidx;

  // decode of the written source number and of the routing window
  always_comb begin
    idx     = wdata[IDX_W-1:0];
    idx_ok  = (wdata < DATA_W'(NUM_SRC));
    cpu_ok  = (int'(cpu) < NUM_CPUS);
    rel     = addr - A_BASE;
    src_hit = (addr >= A_BASE) && (rel < A_SPAN) && (addr[1:0] == 2'b00);
    sidx    = rel[IDX_W+1:2];
  end

  // next-state logic
  always_comb begin
    en_d    = en_q;
    mask_d  = mask_q;
    route_d = route_q;
    if (wr && (bank == BANK_SHARED)) begin
      case (addr)
        A_SET_EN: if (idx_ok && (idx != '0)) en_d[idx] = 1'b1;
        A_CLR_EN: if (idx_ok && (idx != '0)) en_d[idx] = 1'b0;
        default:  if (src_hit) route_d[sidx] = wdata[NUM_CPUS-1:0];
      endcase
    end
    if (wr && (bank == BANK_CPU) && cpu_ok && idx_ok) begin
      case (addr)
        A_SET_MSK: mask_d[cpu][idx] = 1'b1;
        A_CLR_MSK: mask_d[cpu][idx] = 1'b0;
        default:   ;
      endcase
    end
  end

  // state registers, clock enable is the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else if (wr) begin
      en_q    <= en_d;
      mask_q  <= mask_d;
      route_q <= route_d;
    end
  end

  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign route_o = route_q;

  // R3: a set-enable write of a valid number turns that source on
  a_r3_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank == BANK_SHARED && addr == A_SET_EN && idx_ok && idx != '0)
      |=> en_q[$past(idx)]);

  // R3: a clear-enable write of a valid number turns that source off
  a_r3_clr_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank == BANK_SHARED && addr == A_CLR_EN && idx_ok && idx != '0)
      |=> !en_q[$past(idx)]);

  // R3: an out-of-range number leaves the enables alone
  a_r3_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank == BANK_SHARED && (addr == A_SET_EN || addr == A_CLR_EN) && !idx_ok)
      |=> $stable(en_q));

  // R4: set-mask masks the number for the accessing CPU
  a_r4_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank == BANK_CPU && addr == A_SET_MSK && idx_ok && cpu_ok)
      |=> mask_q[$past(cpu)][$past(idx)]);

  // R4: clear-mask unmasks the number for the accessing CPU
  a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank == BANK_CPU && addr == A_CLR_MSK && idx_ok && cpu_ok)
      |=> !mask_q[$past(cpu)][$past(idx)]);

  // R4: a per-CPU access never touches the global enables or routing
  a_r4_cpu_bank_scope: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank == BANK_CPU) |=> ($stable(en_q) && $stable(route_q)));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cand,
  output logic [ACK_W-1:0]   ack
);

  localparam int IDX_W = $clog2(NUM_SRC);

  // lowest index wins; index 0 is the doorbell, so it wins over everything
  always_comb begin
    ack = ACK_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) ack = ACK_W'(i);
    end
  end

  logic [NUM_SRC-1:0] below;
  always_comb begin
    below = (NUM_SRC'(1) << ack[IDX_W-1:0]) - NUM_SRC'(1);
  end

  // R7: a reported number is a candidate and no lower candidate exists
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != ACK_NONE) |-> (cand[ack[IDX_W-1:0]] && ((cand & below) == '0)));

  // R7: "none" only when there is no candidate at all
  a_r7_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == ACK_NONE) |-> (cand == '0));

  // R7: the result is always a real source number or the none code
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == ACK_NONE) || (ack < ACK_W'(NUM_SRC)));

endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CPU_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd,
  input  logic                               bank,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [CPU_W-1:0]                   cpu,
  input  logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route,
  input  logic [NUM_CPUS-1:0][ACK_W-1:0]     ack_all,
  output logic [DATA_W-1:0]                  rdata
);

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFS_SRC_BASE);
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(4 * NUM_SRC);

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] rel;
  logic              src_hit;
  logic [IDX_W-1:0]  sidx;
  logic              cpu_ok;

  always_comb begin
    rel     = addr - A_BASE;
    src_hit = (addr >= A_BASE) && (rel < A_SPAN) && (addr[1:0] == 2'b00);
    sidx    = rel[IDX_W+1:2];
    cpu_ok  = (int'(cpu) < NUM_CPUS);
  end

  // read data selection
  always_comb begin
    rdata_d = '0;
    if (bank == BANK_SHARED) begin
      if (addr == A_CTRL) begin
        rdata_d[11:2] = 10'(NUM_SRC);
      end else if (src_hit) begin
        rdata_d[NUM_CPUS-1:0] = route[sidx];
      end
    end else begin
      if ((addr == A_ACK) && cpu_ok) begin
        rdata_d[ACK_W-1:0] = ack_all[cpu];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R2: the control word reports the source count in bits [11:2]
  a_r2_ctrl_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bank == BANK_SHARED && addr == A_CTRL)
      |=> (rdata[11:2] == 10'(NUM_SRC) && rdata[1:0] == 2'b00));

  // R11: read data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  // R7: the acknowledge word carries nothing above the number field
  a_r7_ack_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bank == BANK_CPU && addr == A_ACK) |=> (rdata[DATA_W-1:ACK_W] == '0));

endmodule

// File: rtl/mcpu_irq_ctrl.sv
module mcpu_irq_ctrl
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_bank,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [CPU_W-1:0]    bus_cpu,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:1]  src_level,
  input  logic [NUM_CPUS-1:0] db_pend,
  output logic [NUM_CPUS-1:0] irq_out
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  logic [NUM_SRC-1:1]               en;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0] route;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] cand;
  logic [NUM_CPUS-1:0][ACK_W-1:0]   ack_all;

  irq_cfg_regs #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CPU_W    (CPU_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr      (bus_wr),
    .bank    (bus_bank),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .cpu     (bus_cpu),
    .en_o    (en),
    .mask_o  (mask),
    .route_o (route)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    // number 0 is the doorbell: only the per-CPU mask gates it
    assign cand[c][0] = db_pend[c] & ~mask[c][0];

    for (genvar n = 1; n < NUM_SRC; n++) begin : g_src
      assign cand[c][n] = src_level[n] & en[n] & ~mask[c][n] & route[n][c];
    end

    irq_pick #(
      .NUM_SRC (NUM_SRC)
    ) u_pick (
      .clk   (clk),
      .rst_n (rst_n_s),
      .cand  (cand[c]),
      .ack   (ack_all[c])
    );

    assign irq_out[c] = (ack_all[c] != ACK_NONE);

    logic routed_any;
    always_comb begin
      routed_any = 1'b0;
      for (int n = 1; n < NUM_SRC; n++) routed_any = routed_any | route[n][c];
    end

    // R8: an unmasked doorbell is reported as number 0
    a_r8_doorbell_first: assert property (@(posedge clk) disable iff (!rst_n_s)
      (db_pend[c] && !mask[c][0]) |-> (ack_all[c] == ACK_DBELL && irq_out[c]));

    // R6: nothing routed and doorbell masked means the CPU stays quiet
    a_r6_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
      (!routed_any && mask[c][0]) |-> !irq_out[c]);
  end

  irq_rd_port #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CPU_W    (CPU_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd      (bus_rd),
    .bank    (bus_bank),
    .addr    (bus_addr),
    .cpu     (bus_cpu),
    .route   (route),
    .ack_all (ack_all),
    .rdata   (bus_rdata)
  );

endmodule

// File: tb/mcpu_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mcpu_irq_ctrl_tb_top;

  localparam int NC = 4;
  localparam int NS = 32;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          bus_wr, bus_rd, bus_bank;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [1:0]    bus_cpu;
  logic [DW-1:0] bus_rdata;
  logic [NS-1:1] src_level;
  logic [NC-1:0] db_pend;
  logic [NC-1:0] irq_out;

  mcpu_irq_ctrl #(.NUM_CPUS(NC), .NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .src_level(src_level),
    .db_pend(db_pend), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state, kept from the requirements
  bit       en_m  [NS];
  bit       msk_m [NC][NS];
  bit [3:0] rt_m  [NS];

  function automatic logic [9:0] exp_ack(int c);
    if (db_pend[c] && !msk_m[c][0]) return 10'd0;
    for (int n = 1; n < NS; n++)
      if (src_level[n] && en_m[n] && !msk_m[c][n] && rt_m[n][c]) return 10'(n);
    return 10'd1023;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(bit bank, int addr, int data, int cpu);
    @(negedge clk);
    bus_wr = 1'b1; bus_bank = bank; bus_addr = AW'(addr);
    bus_wdata = DW'(data); bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_wr = 1'b0;
    if (!bank) begin
      if (addr == 'h30 && data >= 1 && data < NS) en_m[data] = 1'b1;
      if (addr == 'h34 && data >= 1 && data < NS) en_m[data] = 1'b0;
      if (addr >= 'h100 && addr < 'h100 + 4*NS && addr % 4 == 0)
        rt_m[(addr - 'h100) / 4] = 4'(data);
    end else begin
      if (addr == 'h48 && data >= 0 && data < NS) msk_m[cpu][data] = 1'b1;
      if (addr == 'h4C && data >= 0 && data < NS) msk_m[cpu][data] = 1'b0;
    end
  endtask

  task automatic rd_reg(bit bank, int addr, int cpu, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_bank = bank; bus_addr = AW'(addr); bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic chk_cpus(string req);
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      rd_reg(1'b1, 'h44, c, v);
      chk(req, v, {22'd0, exp_ack(c)});
      chk({req, " irq_out"}, {31'd0, irq_out[c]}, {31'd0, (exp_ack(c) != 10'd1023)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_bank = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_cpu = '0; src_level = '0; db_pend = '0;
    for (int n = 0; n < NS; n++) begin
      en_m[n] = 1'b0; rt_m[n] = 4'd0;
      for (int c = 0; c < NC; c++) msk_m[c][n] = 1'b1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, even with every line and doorbell raised
    chk("R1 irq_out after reset", {28'd0, irq_out}, 32'd0);
    src_level = '1; db_pend = '1;
    @(negedge clk);
    chk("R1 irq_out masked", {28'd0, irq_out}, 32'd0);
    chk_cpus("R1");
    rd_reg(1'b0, 'h100 + 4*7, 0, v);
    chk("R1 routing zero", v, 32'd0);
    src_level = '0; db_pend = '0;

    // R2: control word
    rd_reg(1'b0, 'h00, 0, v);
    chk("R2 control", v, 32'(NS) << 2);

    // R5: routing write with junk upper bits reads back trimmed
    wr_reg(1'b0, 'h100 + 4*5, 32'hFFFF_FFF2, 0);
    rd_reg(1'b0, 'h100 + 4*5, 0, v);
    chk("R5 routing readback", v, 32'h2);

    // R6: enable and unmask source 5 for CPU1 only
    wr_reg(1'b0, 'h30, 5, 0);
    wr_reg(1'b1, 'h4C, 5, 1);
    wr_reg(1'b1, 'h4C, 5, 2);
    src_level[5] = 1'b1;
    @(negedge clk);
    chk("R9 irq_out follows", {28'd0, irq_out}, 32'h2);
    chk_cpus("R6 routing gate");

    // R4: masking on CPU2 leaves CPU1 alone; masking CPU1 drops it
    wr_reg(1'b1, 'h48, 5, 2);
    chk_cpus("R4 other cpu mask");
    wr_reg(1'b1, 'h48, 5, 1);
    chk_cpus("R4 own cpu mask");
    wr_reg(1'b1, 'h4C, 5, 1);
    wr_reg(1'b1, 'h48, 37, 1);
    chk_cpus("R4 out-of-range mask");

    // R3: out-of-range clear does not alias onto source 5
    wr_reg(1'b0, 'h34, 37, 0);
    chk_cpus("R3 out-of-range clear");

    // R7: lowest number wins
    for (int n = 3; n <= 9; n += 6) begin
      wr_reg(1'b0, 'h30, n, 0);
      wr_reg(1'b0, 'h100 + 4*n, 4'b0010, 0);
      wr_reg(1'b1, 'h4C, n, 1);
      src_level[n] = 1'b1;
    end
    chk_cpus("R7 lowest wins");

    // R10: repeated reads, then drop the winning line
    rd_reg(1'b1, 'h44, 1, v);
    chk("R10 reread", v, 32'd3);
    rd_reg(1'b1, 'h44, 1, v);
    chk("R10 reread again", v, 32'd3);
    src_level[3] = 1'b0;
    @(negedge clk);
    chk_cpus("R10 level drop");

    // R8: doorbell precedence and its mask
    wr_reg(1'b1, 'h4C, 0, 1);
    db_pend[1] = 1'b1; db_pend[3] = 1'b1;
    @(negedge clk);
    chk_cpus("R8 doorbell");
    db_pend = '0;

    // R3: clear-enable removes the source; set-enable of 0 ignored
    wr_reg(1'b0, 'h34, 5, 0);
    wr_reg(1'b0, 'h30, 0, 0);
    chk_cpus("R3 clear enable");

    // R11: register reads of write-only and unmapped offsets, and hold
    rd_reg(1'b0, 'h30, 0, v);
    chk("R11 set-enable reads zero", v, 32'd0);
    rd_reg(1'b1, 'h48, 1, v);
    chk("R11 set-mask reads zero", v, 32'd0);
    rd_reg(1'b0, 'h200, 0, v);
    chk("R11 unmapped reads zero", v, 32'd0);
    rd_reg(1'b0, 'h00, 0, v);
    wr_reg(1'b0, 'h30, 11, 0);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'(NS) << 2);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      int n;
      op = int'($urandom_range(0, 6));
      n  = int'($urandom_range(0, 35));
      case (op)
        0: wr_reg(1'b0, 'h30, n, 0);
        1: wr_reg(1'b0, 'h34, n, 0);
        2: wr_reg(1'b1, 'h48, n, int'($urandom_range(0, 3)));
        3: wr_reg(1'b1, 'h4C, n, int'($urandom_range(0, 3)));
        4: wr_reg(1'b0, 'h100 + 4*(n % NS), int'($urandom), 0);
        5: begin src_level = (NS-1)'($urandom); @(negedge clk); end
        default: begin db_pend = 4'($urandom); @(negedge clk); end
      endcase
      if (it % 4 == 3) chk_cpus("R7 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule